// File: doc/BRIEF.md
# Selectable Sinc Decimation Filter

This block turns a one-bit delta-sigma stream into multi-bit words. It takes one modulator bit on every clock. Each bit counts as +1 when high and 0 when low. Three integrators run at the bit rate, and a set of differencing stages runs once per output word. A two-bit select chooses one of three responses at run time:

- a third-order sinc;
- a second-order sinc;
- a fast-settling second-order variant, which adds to each second-order result the second-order result from two words earlier.

The decimation ratio is a power of two from 16 to 256. It is given as its base-2 logarithm.

Each output word comes with a one-cycle valid strobe. A settled flag shows that the selected response has filled its whole impulse-response window since the last clear. A controller can then ignore the start-up words that are still incomplete. A new select or ratio takes effect only at a word boundary, and the filter state is cleared at that moment.

Top module: `sinc_decimator`

## Requirements
- R1: With the third-order response (select 2'b00) and ratio N, a settled word equals d·N³, where d is the density of ones in a periodic input whose period divides N. An all-ones input at N=32 gives 32768, and at N=256 it gives 16777216.
- R2: With the second-order response (select 2'b01), a settled word equals d·N².
- R3: With the fast response (select 2'b10), a settled word equals 2·d·N².
- R4: valid_o is high for exactly one cycle every N cycles. N = 2^L, where L is osr_log2 clamped to the range 4..8, so values below 4 act as 4 and values above 8 act as 8.
- R5: Select 2'b11 behaves as the third-order response. Switching between 2'b00 and 2'b11 is not a change: it neither clears the state nor lowers settled_o.
- R6: After a clear, settled_o rises together with the valid of the 3rd word for the third-order response, the 2nd word for second-order, and the 4th word for fast. Otherwise settled_o changes only at a clear.
- R7: A changed select or ratio takes effect only at a word boundary. The word emitted at that boundary still uses the old setting, and settled_o falls together with it. The following words start from cleared state under the new setting.
- R8: The first clock after reset loads the setting, clears the state and ignores mod_bit. Each word covers exactly the N bits since the previous boundary. With zero history and an all-ones input, the first word is C(N+2,3) for third-order and C(N+1,2) for second-order (816 and 136 at N=16).
- R9: data_o is 25 bits wide, right-aligned and unsigned. It changes only together with valid_o, it never exceeds 2^24, and it holds its value between strobes.
- R10: While reset is active, data_o is 0, valid_o is 0 and settled_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock; one bit is taken per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Delta-sigma bit; 1 counts as +1, 0 counts as 0 |
| flt_sel | input | 2 | Response select: 00 third-order, 01 second-order, 10 fast, 11 third-order |
| osr_log2 | input | 4 | Base-2 log of the decimation ratio, clamped to 4..8 |
| data_o | output | 25 | Decimated word |
| valid_o | output | 1 | One-cycle strobe marking a new word |
| settled_o | output | 1 | High once the current response has fully settled since the last clear |

## Verification
The bench drives four input patterns: all zeros, all ones, alternating ones and zeros, and one-in-four. Because the densities differ, the results tell apart a gain error, a wrong integrator tap and a wrong output-rate history in each response. The all-ones first word after a clear shows whether the window is aligned and whether the cleared history is truly zero. Counting the words up to settled_o tells the three orders apart. Changing the setting in the middle of a word shows whether the change waits for the boundary, and a reserved-select switch shows that an equivalent setting causes no clear.

// File: rtl/sinc_dec_pkg.sv
package sinc_dec_pkg;

    typedef enum logic [1:0] {
        FLT_SINC3 = 2'b00,
        FLT_SINC2 = 2'b01,
        FLT_FAST  = 2'b10,
        FLT_RSVD  = 2'b11
    } flt_e;

    // Number of output words after a clear until the response is complete.
    function automatic logic [2:0] settle_words(flt_e f);
        case (f)
            FLT_SINC2: settle_words = 3'd2;
            FLT_FAST:  settle_words = 3'd4;
            default:   settle_words = 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/sinc_dec_ctrl.sv
module sinc_dec_ctrl
    import sinc_dec_pkg::*;
#(
    parameter int LOG2_MIN = 4,
    parameter int LOG2_MAX = 8,
    parameter int LSEL_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        flt_req,
    input  logic [LSEL_W-1:0] osr_req,
    output flt_e              flt_o,
    output logic              dump_o,
    output logic              clr_o,
    output logic              settled_o
);
    localparam int CW = LOG2_MAX;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        flt_e              flt;
        logic [LSEL_W-1:0] lg;
        logic              fresh;
        logic [2:0]        words;
        logic              settled;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [LSEL_W-1:0] req_lg;
    flt_e              req_flt;
    logic [CW:0]       span;
    logic              change;
    logic [2:0]        words_n;

    always_comb begin
        // Normalise the requested setting: clamp the ratio, fold the reserved code.
        if (osr_req < LSEL_W'(LOG2_MIN))      req_lg = LSEL_W'(LOG2_MIN);
        else if (osr_req > LSEL_W'(LOG2_MAX)) req_lg = LSEL_W'(LOG2_MAX);
        else                                  req_lg = osr_req;
        req_flt = (flt_e'(flt_req) == FLT_RSVD) ? FLT_SINC3 : flt_e'(flt_req);

        span    = ((CW+1)'(1) << st_q.lg) - (CW+1)'(1);
        dump_o  = !st_q.fresh && ({1'b0, st_q.cnt} == span);
        change  = (req_flt != st_q.flt) || (req_lg != st_q.lg);
        clr_o   = st_q.fresh || (dump_o && change);
        words_n = (st_q.words == 3'd7) ? st_q.words : st_q.words + 3'd1;

        st_d = st_q;
        if (clr_o) begin
            st_d.cnt     = '0;
            st_d.flt     = req_flt;
            st_d.lg      = req_lg;
            st_d.fresh   = 1'b0;
            st_d.words   = '0;
            st_d.settled = 1'b0;
        end else if (dump_o) begin
            st_d.cnt     = '0;
            st_d.words   = words_n;
            st_d.settled = (words_n >= settle_words(st_q.flt));
        end else begin
            st_d.cnt     = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, flt: FLT_SINC3, lg: LSEL_W'(LOG2_MAX),
                      fresh: 1'b1, words: '0, settled: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flt_o     = st_q.flt;
    assign settled_o = st_q.settled;

endmodule

// File: rtl/sinc_dec_integ.sv
module sinc_dec_integ #(
    parameter int DW     = 25,
    parameter int STAGES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_i,
    input  logic          clr_i,
    output logic [DW-1:0] tap2_o,
    output logic [DW-1:0] tap3_o
);
    logic [STAGES-1:0][DW-1:0] acc_d, acc_q, sum;

    // Chained running sums; each stage adds the freshly updated value of the one before.
    always_comb begin
        for (int k = 0; k < STAGES; k++) begin
            if (k == 0) sum[k] = acc_q[k] + DW'(bit_i);
            else        sum[k] = acc_q[k] + sum[k-1];
        end
        acc_d = clr_i ? '0 : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign tap2_o = sum[1];
    assign tap3_o = sum[STAGES-1];

endmodule

// File: rtl/sinc_dec_comb.sv
module sinc_dec_comb
    import sinc_dec_pkg::*;
#(
    parameter int DW = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] tap2_i,
    input  logic [DW-1:0] tap3_i,
    input  flt_e          flt_i,
    input  logic          dump_i,
    input  logic          clr_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o
);
    localparam int NCOMB = 3;

    typedef struct packed {
        logic [NCOMB-1:0][DW-1:0] dly;
        logic [DW-1:0]            h1;
        logic [DW-1:0]            h2;
        logic [DW-1:0]            data;
        logic                     valid;
    } comb_t;

    comb_t st_d, st_q;
    logic [NCOMB-1:0][DW-1:0] dif;
    logic [DW-1:0]            tap, y;

    always_comb begin
        tap = (flt_i == FLT_SINC3) ? tap3_i : tap2_i;
        for (int k = 0; k < NCOMB; k++) begin
            if (k == 0) dif[k] = tap - st_q.dly[k];
            else        dif[k] = dif[k-1] - st_q.dly[k];
        end
        case (flt_i)
            FLT_SINC2: y = dif[1];
            FLT_FAST:  y = dif[1] + st_q.h2;
            default:   y = dif[2];
        endcase

        st_d       = st_q;
        st_d.valid = dump_i;
        if (dump_i) begin
            st_d.data   = y;
            st_d.dly[0] = tap;
            st_d.dly[1] = dif[0];
            st_d.dly[2] = dif[1];
            st_d.h1     = dif[1];
            st_d.h2     = st_q.h1;
        end
        if (clr_i) begin
            st_d.dly = '0;
            st_d.h1  = '0;
            st_d.h2  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator
    import sinc_dec_pkg::*;
#(
    parameter int LOG2_MIN = 4,
    parameter int LOG2_MAX = 8,
    parameter int LSEL_W   = 4,
    parameter int ORDER    = 3,
    parameter int DW       = ORDER * LOG2_MAX + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_bit,
    input  logic [1:0]        flt_sel,
    input  logic [LSEL_W-1:0] osr_log2,
    output logic [DW-1:0]     data_o,
    output logic              valid_o,
    output logic              settled_o
);
    flt_e          flt;
    logic          dump, clr;
    logic [DW-1:0] tap2, tap3;

    sinc_dec_ctrl #(
        .LOG2_MIN(LOG2_MIN), .LOG2_MAX(LOG2_MAX), .LSEL_W(LSEL_W)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .flt_req(flt_sel), .osr_req(osr_log2),
        .flt_o(flt), .dump_o(dump), .clr_o(clr), .settled_o(settled_o)
    );

    sinc_dec_integ #(.DW(DW), .STAGES(ORDER)) i_integ (
        .clk(clk), .rst_n(rst_n), .bit_i(mod_bit), .clr_i(clr),
        .tap2_o(tap2), .tap3_o(tap3)
    );

    sinc_dec_comb #(.DW(DW)) i_comb (
        .clk(clk), .rst_n(rst_n), .tap2_i(tap2), .tap3_i(tap3), .flt_i(flt),
        .dump_i(dump), .clr_i(clr), .data_o(data_o), .valid_o(valid_o)
    );

endmodule

// File: rtl/sinc_decimator_chk.sv
module sinc_decimator_chk #(
    parameter int DW = 25
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] data_o,
    input logic          valid_o,
    input logic          settled_o
);
    // R4: a word strobe never lasts more than one cycle
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: settling is announced only together with a word
    p_settle_with_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled_o) |-> valid_o);

    // R7: settled drops only at the boundary where a new setting takes effect
    p_settle_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(settled_o) |-> valid_o);

    // R9: the word register only moves with a strobe
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> valid_o);

    // R9: no word goes above the full-scale bound
    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (data_o <= (DW'(1) << (DW - 1))));

endmodule

bind sinc_decimator sinc_decimator_chk #(.DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .data_o(data_o), .valid_o(valid_o), .settled_o(settled_o)
);

// File: tb/test_sinc_decimator.sv
module test_sinc_decimator;
    localparam int DW = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mod_bit = 1'b0;
    logic [1:0]    flt_sel = 2'b00;
    logic [3:0]    osr_log2 = 4'd4;
    logic [DW-1:0] data_o;
    logic          valid_o, settled_o;

    int tests = 0;
    int fails = 0;
    int pat   = 1;   // 0 zeros, 1 ones, 2 alternating, 3 one-in-four
    int ph    = 0;

    always #10 clk = ~clk;

    sinc_decimator i_sinc_decimator (
        .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .flt_sel(flt_sel),
        .osr_log2(osr_log2), .data_o(data_o), .valid_o(valid_o), .settled_o(settled_o)
    );

    always @(negedge clk) begin
        ph <= ph + 1;
        case (pat)
            0: mod_bit <= 1'b0;
            1: mod_bit <= 1'b1;
            2: mod_bit <= (ph % 2) == 0;
            default: mod_bit <= (ph % 4) == 0;
        endcase
    end

    task automatic chk(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected settled word: density num/den, ratio 2^lg, select f.
    function automatic longint expect_word(int f, int lg, int num, int den);
        longint n = longint'(1) << lg;
        longint g = (f == 1) ? n * n : (f == 2) ? 2 * n * n : n * n * n;
        return (g * num) / den;
    endfunction

    task automatic reset_dut(int f, int lg);
        flt_sel  = 2'(f);
        osr_log2 = 4'(lg);
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n    = 1'b1;
    endtask

    task automatic next_word(string req, output longint d, output bit s);
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (valid_o) begin
                d = longint'(data_o);
                s = settled_o;
                return;
            end
        end
        d = -1;
        s = 1'b0;
        tests++;
        fails++;
        $display("FAIL %s: actual no word expected a word", req);
    endtask

    task automatic wait_settled(string req);
        longint d;
        bit s;
        for (int i = 0; i < 8; i++) begin
            next_word(req, d, s);
            if (s) return;
        end
        chk(req, 0, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 data", longint'(data_o), 0);
        chk("R10 valid", longint'(valid_o), 0);
        chk("R10 settled", longint'(settled_o), 0);
    endtask

    task automatic t_settle(int f, int need, string req);
        longint d;
        bit s;
        int at = 0;
        pat = 1;
        reset_dut(f, 4);
        for (int i = 1; i <= 6; i++) begin
            next_word(req, d, s);
            if (s && at == 0) at = i;
        end
        chk(req, at, need);
    endtask

    task automatic t_steady(int f, int lg, int p, int num, int den, string req);
        longint d;
        bit s;
        pat = p;
        reset_dut(f, lg);
        wait_settled(req);
        next_word(req, d, s);
        chk(req, d, expect_word(f, lg, num, den));
    endtask

    task automatic t_first_word(int f, longint exp, string req);
        longint d;
        bit s;
        pat = 1;
        reset_dut(f, 4);
        next_word(req, d, s);
        chk(req, d, exp);
    endtask

    task automatic t_spacing(int lg_in, int span, string req);
        longint d;
        bit s;
        int gap = 0;
        pat = 1;
        reset_dut(0, lg_in);
        next_word(req, d, s);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            gap++;
            if (valid_o) break;
        end
        chk(req, gap, span);
    endtask

    task automatic t_change();
        longint d;
        bit s;
        pat = 1;
        reset_dut(0, 4);
        wait_settled("R7 pre");
        flt_sel = 2'b01;                      // request change mid-word
        next_word("R7 boundary", d, s);
        chk("R7 old setting word", d, 4096);
        chk("R7 settled falls", longint'(s), 0);
        next_word("R7 first new", d, s);
        chk("R7 cleared first word", d, 136);
        chk("R6 sinc2 not yet", longint'(s), 0);
        next_word("R7 second new", d, s);
        chk("R6 sinc2 settles", longint'(s), 1);
        chk("R2 after change", d, 256);
    endtask

    task automatic t_reserved();
        longint d;
        bit s;
        pat = 1;
        reset_dut(0, 4);
        wait_settled("R5 pre");
        flt_sel = 2'b11;
        next_word("R5 a", d, s);
        chk("R5 no clear settled", longint'(s), 1);
        chk("R5 value", d, 4096);
        next_word("R5 b", d, s);
        chk("R5 acts as third-order", d, 4096);
        chk("R9 hold between words", longint'(data_o), 4096);
    endtask

    initial begin
        t_reset();
        t_steady(0, 4, 1, 1, 1, "R1 ones N16");
        t_steady(0, 4, 0, 0, 1, "R1 zeros");
        t_steady(0, 4, 2, 1, 2, "R1 alternating");
        t_steady(0, 4, 3, 1, 4, "R1 quarter");
        t_steady(0, 5, 1, 1, 1, "R1 full scale N32");
        t_steady(0, 8, 1, 1, 1, "R1 full scale N256");
        t_steady(1, 4, 1, 1, 1, "R2 ones");
        t_steady(1, 4, 3, 1, 4, "R2 quarter");
        t_steady(2, 4, 1, 1, 1, "R3 ones");
        t_steady(2, 4, 2, 1, 2, "R3 alternating");
        t_steady(2, 8, 1, 1, 1, "R3 ones N256");
        t_steady(3, 4, 2, 1, 2, "R5 reserved alternating");
        t_settle(0, 3, "R6 sinc3 words");
        t_settle(1, 2, "R6 sinc2 words");
        t_settle(2, 4, "R6 fast words");
        t_first_word(0, 816, "R8 sinc3 first");
        t_first_word(1, 136, "R8 sinc2 first");
        t_spacing(2, 16, "R4 clamp low");
        t_spacing(5, 32, "R4 N32");
        t_spacing(13, 256, "R4 clamp high");
        t_change();
        t_reserved();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule